// File: doc/BRIEF.md
# PHY Management Register Model

This block models the management side of a 10/100 Ethernet PHY as a MAC's management command registers see it. The host writes three MAC-side registers through one narrow write port. It writes an address register that names a PHY and a register inside it. It writes a transmit-data register that carries a write value. It writes a command register whose bits start a write, a read, or continuous link scanning. Behind these registers sits a bank of sixteen 16-bit PHY registers. They hold fixed identity values, a control register with a self-clearing soft reset, and a status register and a link-partner ability register that follow a link input.

Only one PHY address answers. A read captures the addressed register into a read-data output and raises a one-cycle valid pulse. A read also captures the link-fail state. Serial bit timing is not modelled: every management access completes on the clock edge that accepts it.

Top module: `phy_mgmt_model`

## Requirements
- R1: After reset the PHY registers read 0x1000 (reg 0), 0x7848 (reg 1), 0x2000 (reg 2), 0x5C90 (reg 3), 0x01E1 (reg 4) and 0x0000 (regs 5 to 15), while the link input is low.
- R2: The `wr_sel_i` encoding is 0 for the address register, 1 for transmit data and 2 for command; 3 is ignored. The address register takes the PHY address from bits 4:0 and the register address from bits 12:8. Only PHY address 1 responds: a read at any other PHY address returns 0xFFFF, and writes there change nothing.
- R3: A command with bit 1 set is a read. `rd_data_o` and a one-cycle `rd_valid_o` pulse appear after the accepting clock edge. `rd_data_o` holds its value until the next read.
- R4: A transmit-data write also writes its value at once to the addressed PHY register. A command with bit 2 set writes the last transmit-data value to the addressed PHY register.
- R5: Registers 1, 2 and 3 ignore writes, and registers 4 to 15 store any value written. Register addresses 16 to 31 ignore writes and read as 0.
- R6: A write to register 0 with bit 15 set reloads every reset default and is not itself stored. A write with bit 15 clear is stored as written.
- R7: On a rise of `link_up_i`, bit 2 of register 1 is set and 0x01E1 is ORed into register 5. On a fall, bit 2 is cleared and register 5 is ANDed with 0x01FF. Each change takes effect on the first clock edge that sees the new level.
- R8: After a soft reset, and after reset is released, registers 1 and 5 reflect the current link level.
- R9: A read command loads `link_fail_o` with the inverse of `link_up_i`. Without a read or scan, `link_fail_o` holds.
- R10: A command with bit 0 set starts a scan, during which `link_fail_o` follows the inverse of `link_up_i` on every clock. Any command with bit 0 clear stops the scan.
- R11: A command with both bit 2 and bit 1 set writes first and returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the management registers |
| wr_sel_i | input | 2 | Target: 0 address, 1 transmit data, 2 command |
| wr_data_i | input | 16 | Write value |
| link_up_i | input | 1 | Link level, high when up |
| rd_data_o | output | 16 | Read data captured by the last read command |
| rd_valid_o | output | 1 | One-cycle pulse after a read command |
| link_fail_o | output | 1 | Link-fail status bit |

## Verification
The bench goes after the register-0 soft reset. A design that stores the reset value, or that skips the link bits when it reloads, shows a wrong register 1 or 5 on the next read. It also drives link transitions over a register 5 pattern the host wrote. Mixing up the OR and the AND masks there shows as stray or lost upper bits. A combined write-and-read command catches a read path that returns the old value. Reads at foreign PHY addresses and at register addresses of 16 and above catch address decoding that answers too widely. Scan on and scan off separate a link-fail bit that tracks too eagerly from one that never tracks.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_TXD  = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_NONE = 2'd3
  } mgmt_sel_e;

  localparam int CMD_WR_BIT   = 2;
  localparam int CMD_RD_BIT   = 1;
  localparam int CMD_SCAN_BIT = 0;

  localparam int REG_LSB = 8;

  localparam int IDX_CTRL    = 0;
  localparam int IDX_STAT    = 1;
  localparam int IDX_RO_LAST = 3;
  localparam int IDX_PARTNER = 5;

  localparam logic [15:0] LINK_BIT     = 16'h0004;
  localparam logic [15:0] PARTNER_SET  = 16'h01E1;
  localparam logic [15:0] PARTNER_KEEP = 16'h01FF;

  function automatic logic [15:0] reg_default(int idx);
    case (idx)
      0:       return 16'h1000;
      1:       return 16'h7848;
      2:       return 16'h2000;
      3:       return 16'h5C90;
      4:       return 16'h01E1;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/phy_cmd_decode.sv
module phy_cmd_decode
  import phy_mgmt_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int PHY_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] phy_addr_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              phy_hit_o,
  output logic              phy_wr_o,
  output logic [DATA_W-1:0] phy_wr_data_o,
  output logic              rd_strobe_o,
  output logic              scan_o
);

  localparam logic [ADDR_W-1:0] OWN_ADDR = ADDR_W'(PHY_ADDR);

  logic [ADDR_W-1:0] phy_addr_q, reg_addr_q;
  logic [DATA_W-1:0] txd_q;
  logic              scan_q;
  logic              is_addr, is_txd, is_cmd;

  assign is_addr = wr_en_i && (wr_sel_i == SEL_ADDR);
  assign is_txd  = wr_en_i && (wr_sel_i == SEL_TXD);
  assign is_cmd  = wr_en_i && (wr_sel_i == SEL_CMD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phy_addr_q <= '0;
      reg_addr_q <= '0;
      txd_q      <= '0;
      scan_q     <= 1'b0;
    end else begin
      if (is_addr) begin
        phy_addr_q <= wr_data_i[ADDR_W-1:0];
        reg_addr_q <= wr_data_i[REG_LSB+ADDR_W-1:REG_LSB];
      end
      if (is_txd) txd_q <= wr_data_i;
      if (is_cmd) scan_q <= wr_data_i[CMD_SCAN_BIT];
    end
  end

  assign phy_hit_o     = (phy_addr_q == OWN_ADDR);
  // transmit-data writes go straight through; command writes use the held value
  assign phy_wr_o      = phy_hit_o && (is_txd || (is_cmd && wr_data_i[CMD_WR_BIT]));
  assign phy_wr_data_o = is_txd ? wr_data_i : txd_q;
  assign rd_strobe_o   = is_cmd && wr_data_i[CMD_RD_BIT];
  assign phy_addr_o    = phy_addr_q;
  assign reg_addr_o    = reg_addr_q;
  assign scan_o        = scan_q;

endmodule

// File: rtl/phy_reg_file.sv
module phy_reg_file
  import phy_mgmt_pkg::*;
#(
  parameter int REG_CNT = 16,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              link_up_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int                IDX_W     = $clog2(REG_CNT);
  localparam logic [ADDR_W:0]   REG_LIMIT = (ADDR_W+1)'(REG_CNT);
  localparam logic [ADDR_W-1:0] RO_LAST   = ADDR_W'(IDX_RO_LAST);

  logic [DATA_W-1:0] regs_q [REG_CNT];
  logic [DATA_W-1:0] regs_d [REG_CNT];
  logic              link_q;
  logic              wr_in_range, rd_in_range, soft_rst;

  assign wr_in_range = {1'b0, wr_addr_i} < REG_LIMIT;
  assign rd_in_range = {1'b0, rd_addr_i} < REG_LIMIT;
  assign soft_rst    = wr_en_i && wr_in_range && (wr_addr_i == '0) && wr_data_i[DATA_W-1];

  always_comb begin
    for (int i = 0; i < REG_CNT; i++) regs_d[i] = regs_q[i];
    if (wr_en_i && wr_in_range && !soft_rst) begin
      if (wr_addr_i == '0) regs_d[IDX_CTRL] = wr_data_i;
      else if (wr_addr_i > RO_LAST) regs_d[wr_addr_i[IDX_W-1:0]] = wr_data_i;
    end
    if (soft_rst) begin
      for (int i = 0; i < REG_CNT; i++) regs_d[i] = DATA_W'(reg_default(i));
    end
    // link level is reapplied on every change and after a soft reset
    if (soft_rst || (link_up_i != link_q)) begin
      if (link_up_i) begin
        regs_d[IDX_STAT]    = regs_d[IDX_STAT] | DATA_W'(LINK_BIT);
        regs_d[IDX_PARTNER] = regs_d[IDX_PARTNER] | DATA_W'(PARTNER_SET);
      end else begin
        regs_d[IDX_STAT]    = regs_d[IDX_STAT] & ~DATA_W'(LINK_BIT);
        regs_d[IDX_PARTNER] = regs_d[IDX_PARTNER] & DATA_W'(PARTNER_KEEP);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < REG_CNT; i++) regs_q[i] <= DATA_W'(reg_default(i));
      link_q <= 1'b0;
    end else begin
      for (int i = 0; i < REG_CNT; i++) regs_q[i] <= regs_d[i];
      link_q <= link_up_i;
    end
  end

  // next-state read so a same-cycle write is visible
  assign rd_data_o = rd_in_range ? regs_d[rd_addr_i[IDX_W-1:0]] : '0;

endmodule

// File: rtl/phy_mgmt_model.sv
module phy_mgmt_model
  import phy_mgmt_pkg::*;
#(
  parameter int REG_CNT  = 16,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int PHY_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              link_up_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              link_fail_o
);

  logic [ADDR_W-1:0] phy_addr, reg_addr;
  logic              phy_hit, phy_wr, rd_strobe, scan;
  logic [DATA_W-1:0] phy_wr_data, file_rd;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q, link_fail_q;

  phy_cmd_decode #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PHY_ADDR(PHY_ADDR)
  ) u_decode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (wr_sel_i),
    .wr_data_i    (wr_data_i),
    .phy_addr_o   (phy_addr),
    .reg_addr_o   (reg_addr),
    .phy_hit_o    (phy_hit),
    .phy_wr_o     (phy_wr),
    .phy_wr_data_o(phy_wr_data),
    .rd_strobe_o  (rd_strobe),
    .scan_o       (scan)
  );

  phy_reg_file #(
    .REG_CNT(REG_CNT),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (phy_wr),
    .wr_addr_i(reg_addr),
    .wr_data_i(phy_wr_data),
    .link_up_i(link_up_i),
    .rd_addr_i(reg_addr),
    .rd_data_o(file_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q   <= '0;
      rd_valid_q  <= 1'b0;
      link_fail_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_strobe;
      if (rd_strobe) rd_data_q <= phy_hit ? file_rd : '1;
      if (rd_strobe || scan) link_fail_q <= ~link_up_i;
    end
  end

  assign rd_data_o   = rd_data_q;
  assign rd_valid_o  = rd_valid_q;
  assign link_fail_o = link_fail_q;

endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int PHY_ADDR = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_strobe,
  input logic              scan,
  input logic [ADDR_W-1:0] phy_addr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              link_up_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_valid_o,
  input logic              link_fail_o
);

  logic own;
  assign own = (phy_addr == ADDR_W'(PHY_ADDR));

  assert_foreign_phy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe && !own) |=> (rd_data_o == '1));

  assert_valid_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe |=> rd_valid_o);

  assert_no_spurious_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_strobe |=> !rd_valid_o);

  assert_rd_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_strobe |=> $stable(rd_data_o));

  assert_ro_stat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe && own && reg_addr == ADDR_W'(1)) |=> ((rd_data_o & 16'hFFFB) == 16'h7848));

  assert_ro_id_hi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe && own && reg_addr == ADDR_W'(2)) |=> (rd_data_o == 16'h2000));

  assert_ro_id_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe && own && reg_addr == ADDR_W'(3)) |=> (rd_data_o == 16'h5C90));

  assert_high_addr_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe && own && reg_addr >= ADDR_W'(16)) |=> (rd_data_o == '0));

  assert_link_fail_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe |=> (link_fail_o == !$past(link_up_i)));

  assert_scan_track_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan |=> (link_fail_o == !$past(link_up_i)));

  assert_link_fail_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_strobe && !scan) |=> $stable(link_fail_o));

endmodule

bind phy_mgmt_model phy_mgmt_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .PHY_ADDR(PHY_ADDR)
) u_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_strobe  (rd_strobe),
  .scan       (scan),
  .phy_addr   (phy_addr),
  .reg_addr   (reg_addr),
  .link_up_i  (link_up_i),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o),
  .link_fail_o(link_fail_o)
);

// File: tb/tb_phy_mgmt_model.sv
module tb_phy_mgmt_model;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd3;
  logic [15:0] wr_data_i = '0;
  logic        link_up_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        rd_valid_o;
  logic        link_fail_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] model [16];
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  phy_mgmt_model dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .link_up_i  (link_up_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .link_fail_o(link_fail_o)
  );

  function automatic logic [15:0] dflt(int i);
    case (i)
      0: return 16'h1000;
      1: return 16'h7848;
      2: return 16'h2000;
      3: return 16'h5C90;
      4: return 16'h01E1;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_link();
    if (link_up_i) begin
      model[1] = model[1] | 16'h0004;
      model[5] = model[5] | 16'h01E1;
    end else begin
      model[1] = model[1] & 16'hFFFB;
      model[5] = model[5] & 16'h01FF;
    end
  endtask

  task automatic model_write(int idx, logic [15:0] d);
    if (idx < 16) begin
      if (idx == 0 && d[15]) begin
        for (int i = 0; i < 16; i++) model[i] = dflt(i);
        model_link();
      end else if (idx == 0 || idx > 3) begin
        model[idx] = d;
      end
    end
  endtask

  function automatic logic [15:0] model_read(int idx);
    return (idx < 16) ? model[idx] : 16'h0000;
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(logic [1:0] sel, logic [15:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_sel_i = 2'd3;
  endtask

  task automatic set_addr(int phy, int rg);
    bus(2'd0, {3'b000, 5'(rg), 3'b000, 5'(phy)});
  endtask

  task automatic phy_write(int rg, logic [15:0] d);
    set_addr(1, rg);
    bus(2'd1, d);
    model_write(rg, d);
  endtask

  task automatic read_check(int phy, int rg, string req);
    logic [15:0] exp;
    set_addr(phy, rg);
    bus(2'd2, 16'h0002);
    exp = (phy == 1) ? model_read(rg) : 16'hFFFF;
    check(rd_data_o == exp, req, rd_data_o, exp);
    check(rd_valid_o == 1'b1, "R3", {15'b0, rd_valid_o}, 16'h0001);
  endtask

  task automatic set_link(logic v);
    link_up_i = v;
    @(negedge clk_i);
    model_link();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) model[i] = dflt(i);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: reset state
    check(rd_valid_o == 1'b0 && link_fail_o == 1'b0, "R1", {14'b0, rd_valid_o, link_fail_o}, 16'h0000);
    for (int i = 0; i < 16; i++) read_check(1, i, "R1");

    // R3: valid drops, data holds
    @(negedge clk_i);
    check(rd_valid_o == 1'b0, "R3", {15'b0, rd_valid_o}, 16'h0000);
    bus(2'd0, 16'h0401);
    bus(2'd3, 16'hFFFF);
    check(rd_data_o == model[15], "R3", rd_data_o, model[15]);

    // R5: read-only and high addresses
    phy_write(1, 16'hFFFF); read_check(1, 1, "R5");
    phy_write(2, 16'h1234); read_check(1, 2, "R5");
    phy_write(3, 16'h0000); read_check(1, 3, "R5");
    phy_write(7, 16'hBEEF); read_check(1, 7, "R5");
    phy_write(20, 16'h5555); read_check(1, 20, "R5");

    // R2: foreign PHY writes ignored, reads return all ones
    set_addr(3, 7); bus(2'd1, 16'h1111);
    read_check(3, 7, "R2");
    read_check(1, 7, "R2");

    // R6: plain store, then soft reset
    phy_write(0, 16'h3100); read_check(1, 0, "R6");
    phy_write(4, 16'hAAAA);
    phy_write(0, 16'h8000);
    read_check(1, 0, "R6"); read_check(1, 4, "R6"); read_check(1, 7, "R6");

    // R7: link masks over a written reg 5
    phy_write(5, 16'hFE00);
    set_link(1'b1);
    read_check(1, 1, "R7"); read_check(1, 5, "R7");
    check(rd_data_o == 16'hFFE1, "R7", rd_data_o, 16'hFFE1);
    set_link(1'b0);
    read_check(1, 5, "R7");
    check(rd_data_o == 16'h01E1, "R7", rd_data_o, 16'h01E1);

    // R8: soft reset with link up
    set_link(1'b1);
    phy_write(0, 16'h8000);
    read_check(1, 1, "R8"); read_check(1, 5, "R8");
    check(rd_data_o == 16'h01E1, "R8", rd_data_o, 16'h01E1);

    // R9: link fail loaded on read, held otherwise
    check(link_fail_o == 1'b0, "R9", {15'b0, link_fail_o}, 16'h0000);
    set_link(1'b0);
    repeat (2) @(negedge clk_i);
    check(link_fail_o == 1'b0, "R9", {15'b0, link_fail_o}, 16'h0000);
    read_check(1, 1, "R9");
    check(link_fail_o == 1'b1, "R9", {15'b0, link_fail_o}, 16'h0001);

    // R10: scan on, then off
    bus(2'd2, 16'h0001);
    set_link(1'b1);
    check(link_fail_o == 1'b0, "R10", {15'b0, link_fail_o}, 16'h0000);
    set_link(1'b0);
    check(link_fail_o == 1'b1, "R10", {15'b0, link_fail_o}, 16'h0001);
    set_link(1'b1);
    bus(2'd2, 16'h0000);
    set_link(1'b0);
    @(negedge clk_i);
    check(link_fail_o == 1'b0, "R10", {15'b0, link_fail_o}, 16'h0000);

    // R4/R11: command write from held data, combined with read
    set_addr(2, 9); bus(2'd1, 16'hABCD);
    set_addr(1, 9); bus(2'd2, 16'h0006);
    model_write(9, 16'hABCD);
    check(rd_data_o == 16'hABCD, "R11", rd_data_o, 16'hABCD);
    read_check(1, 9, "R4");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op, rg;
      op = int'($urandom % 5);
      rg = int'($urandom % 20);
      d  = 16'($urandom);
      case (op)
        0: begin
          if (rg == 0 && ($urandom % 4) != 0) d[15] = 1'b0;
          phy_write(rg, d);
        end
        1: begin
          if (rg == 0) d[15] = 1'b0;
          set_addr(5, rg); bus(2'd1, d);
          set_addr(1, rg); bus(2'd2, 16'h0004);
          model_write(rg, d);
        end
        2: read_check(1, rg, "R4");
        3: set_link(~link_up_i);
        default: read_check(int'($urandom % 31) + 2, rg, "R2");
      endcase
    end
    for (int i = 0; i < 16; i++) read_check(1, i, "R5");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule